// File: doc/BRIEF.md
# Receive Slip Buffer

This block absorbs wander between a recovered line clock and a local system clock. Serial bits arrive under a write strobe and leave under a read strobe. Both strobes are clock enables on a single clock, and they stand in for the two rates. Between the two sides sits a 512-bit circular store, arranged as 64 channels of 8 bits.

The read side trails the write side by a nominal 28 channels. The channel separation is measured each time a read starts a new channel. If the read side has come within 15 channels of the write side, or has fallen more than 41 channels behind it, the read pointer is moved to 28 channels behind the current write channel. Channel framing is kept intact by this slip. One of two one-cycle pulses reports its direction: a repeat when the read side was too close, and a delete when it was too far behind. The band from 15 to 41 channels gives ±13 channels of hysteresis around the nominal point, which is 26 channels or 208 UI of wander tolerance.

Top module: `slip_buffer`

## Requirements
- R1: Each cycle with `wr_en_i` high stores `wr_bit_i` at bit address `wr_ptr` and then advances `wr_ptr` by one, wrapping from 511 to 0. Bit address = channel*8 + bit index, with bit index 0 first in a channel.
- R2: Each cycle with `rd_en_i` high loads `rd_bit_o` on the next edge with the stored bit at the effective read address, then advances the read pointer from that address. With `rd_en_i` low, `rd_bit_o` holds. A read and a write to the same address in the same cycle return the old bit.
- R3: After reset the write pointer is 0, the read pointer is bit address 288 (channel 36, which is 28 channels behind), all stored bits are 0, and all outputs are 0.
- R4: Separation is (write channel − read channel) mod 64. It is evaluated only on a read strobe whose read pointer bit index is 0.
- R5: If separation < 15 at evaluation, the effective read address becomes ((write channel − 28) mod 64)*8, and `slip_repeat_o` is high for exactly the next cycle.
- R6: If separation > 41 at evaluation, the same re-centring happens and `slip_delete_o` is high for exactly the next cycle.
- R7: Separation from 15 to 41 inclusive causes no slip. Right after a slip, the separation is 28 or 29 channels.
- R8: No slip occurs on a read whose bit index is nonzero, whatever the separation.
- R9: `slip_repeat_o` and `slip_delete_o` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Line-side bit strobe |
| wr_bit_i | input | 1 | Line-side data bit |
| rd_en_i | input | 1 | System-side bit strobe |
| rd_bit_o | output | 1 | System-side data bit, registered |
| slip_repeat_o | output | 1 | One-cycle pulse, read re-centred backwards |
| slip_delete_o | output | 1 | One-cycle pulse, read re-centred forwards |

## Verification
Equal strobe rates with pseudo-random data show that data written arrives exactly 28 channels later and that no slip fires inside the band. A read rate of twice the write rate drives the separation down until repeats occur. A write rate of twice the read rate drives it up until deletes occur. Together these two patterns separate the two thresholds and the two pulse directions. Idle periods and long runs of random independent strobes exercise reads that start mid-channel, coincident strobes and holding of the output, all against a bit-level reference model of the pointers.

// File: rtl/slip_buffer_pkg.sv
package slip_buffer_pkg;
  typedef enum logic [1:0] {
    SLIP_NONE   = 2'd0,
    SLIP_REPEAT = 2'd1,
    SLIP_DELETE = 2'd2
  } slip_e;
endpackage

// File: rtl/sb_ptr.sv
module sb_ptr #(
  parameter int          W       = 9,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] ptr_o
);
  logic [W-1:0] base;
  assign base = ld_i ? ld_val_i : ptr_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ptr_o <= RST_VAL;
    else if (en_i) ptr_o <= base + W'(1);
  end

  // R1: plain advance when not loaded
  a_r1_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !ld_i) |=> ptr_o == $past(ptr_o) + W'(1));
  a_r2_ptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(ptr_o));
endmodule

// File: rtl/sb_store.sv
module sb_store #(
  parameter int DEPTH = 512,
  parameter int AW    = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic          wbit_i,
  input  logic [AW-1:0] raddr_i,
  output logic          rbit_o
);
  logic [DEPTH-1:0] mem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   mem_q <= '0;
    else if (we_i) mem_q[waddr_i] <= wbit_i;
  end

  assign rbit_o = mem_q[raddr_i];  // old value on same-cycle collision

  a_r1_store_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wbit_i));
endmodule

// File: rtl/sb_slip_ctrl.sv
module sb_slip_ctrl
  import slip_buffer_pkg::*;
#(
  parameter int N_CH     = 64,
  parameter int CH_W     = 8,
  parameter int SLIP_OFS = 28,
  parameter int LO_TH    = 15,
  parameter int HI_TH    = 41,
  localparam int CW      = $clog2(N_CH),
  localparam int BW      = $clog2(CH_W),
  localparam int AW      = CW + BW
) (
  input  logic [CW-1:0] wr_ch_i,
  input  logic [AW-1:0] rd_ptr_i,
  input  logic          rd_en_i,
  output slip_e         slip_o,
  output logic [AW-1:0] rd_addr_o
);
  logic [CW-1:0] rd_ch, sep, tgt_ch;
  logic          at_bound;

  assign rd_ch    = rd_ptr_i[AW-1:BW];
  assign at_bound = (rd_ptr_i[BW-1:0] == '0);
  assign sep      = wr_ch_i - rd_ch;
  assign tgt_ch   = wr_ch_i - CW'(SLIP_OFS);

  always_comb begin
    slip_o = SLIP_NONE;
    if (rd_en_i && at_bound) begin
      if (int'(sep) < LO_TH)      slip_o = SLIP_REPEAT;
      else if (int'(sep) > HI_TH) slip_o = SLIP_DELETE;
    end
    rd_addr_o = (slip_o == SLIP_NONE) ? rd_ptr_i : {tgt_ch, {BW{1'b0}}};
  end
endmodule

// File: rtl/slip_buffer.sv
module slip_buffer
  import slip_buffer_pkg::*;
#(
  parameter int N_CH     = 64,
  parameter int CH_W     = 8,
  parameter int SLIP_OFS = 28,
  parameter int LO_TH    = 15,
  parameter int HI_TH    = 41
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  logic wr_bit_i,
  input  logic rd_en_i,
  output logic rd_bit_o,
  output logic slip_repeat_o,
  output logic slip_delete_o
);
  localparam int DEPTH = N_CH * CH_W;
  localparam int CW    = $clog2(N_CH);
  localparam int BW    = $clog2(CH_W);
  localparam int AW    = CW + BW;
  localparam logic [AW-1:0] RD_RST = AW'(((N_CH - SLIP_OFS) % N_CH) * CH_W);

  logic [AW-1:0] wr_ptr, rd_ptr, rd_addr;
  logic          rd_bit_c;
  slip_e         slip;

  sb_ptr #(.W(AW), .RST_VAL('0)) u_wr_ptr (
    .clk_i, .rst_ni, .en_i(wr_en_i), .ld_i(1'b0), .ld_val_i('0), .ptr_o(wr_ptr)
  );

  sb_ptr #(.W(AW), .RST_VAL(RD_RST)) u_rd_ptr (
    .clk_i, .rst_ni, .en_i(rd_en_i), .ld_i(slip != SLIP_NONE),
    .ld_val_i(rd_addr), .ptr_o(rd_ptr)
  );

  sb_slip_ctrl #(
    .N_CH(N_CH), .CH_W(CH_W), .SLIP_OFS(SLIP_OFS), .LO_TH(LO_TH), .HI_TH(HI_TH)
  ) u_ctrl (
    .wr_ch_i(wr_ptr[AW-1:BW]), .rd_ptr_i(rd_ptr), .rd_en_i,
    .slip_o(slip), .rd_addr_o(rd_addr)
  );

  sb_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i, .rst_ni, .we_i(wr_en_i), .waddr_i(wr_ptr), .wbit_i(wr_bit_i),
    .raddr_i(rd_addr), .rbit_o(rd_bit_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_bit_o      <= 1'b0;
      slip_repeat_o <= 1'b0;
      slip_delete_o <= 1'b0;
    end else begin
      if (rd_en_i) rd_bit_o <= rd_bit_c;
      slip_repeat_o <= (slip == SLIP_REPEAT);
      slip_delete_o <= (slip == SLIP_DELETE);
    end
  end

  logic [CW-1:0] post_sep;
  assign post_sep = wr_ptr[AW-1:BW] - rd_ptr[AW-1:BW];

  a_r9_slip_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(slip_repeat_o && slip_delete_o));
  a_r2_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_bit_o));
  // R7: re-centred separation right after a slip
  a_r7_recentre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_repeat_o || slip_delete_o) |->
      (int'(post_sep) == SLIP_OFS || int'(post_sep) == SLIP_OFS + 1));
  // R8: slip starts a channel, one bit consumed
  a_r8_slip_aligned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slip_repeat_o || slip_delete_o) |-> rd_ptr[BW-1:0] == BW'(1));
  a_r5_repeat_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_ptr[BW-1:0] != '0) |=> !slip_repeat_o && !slip_delete_o);
endmodule

// File: tb/slip_buffer_test.sv
module slip_buffer_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, wr_bit = 1'b0, rd_en = 1'b0;
  logic rd_bit, slip_rep, slip_del;

  always #4 clk = ~clk;  // 125 MHz

  slip_buffer uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_bit_i(wr_bit),
    .rd_en_i(rd_en), .rd_bit_o(rd_bit), .slip_repeat_o(slip_rep),
    .slip_delete_o(slip_del)
  );

  int checks = 0, errors = 0;
  bit m [512];
  int wp, rp;
  bit exp_bit, exp_rep, exp_del;
  int n_rep, n_del;
  logic [15:0] lfsr = 16'hACE1;

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // one cycle; reference model from the requirements
  task automatic step(bit we, bit wb, bit re);
    int sep, eff;
    wr_en = we; wr_bit = wb; rd_en = re;
    @(posedge clk);
    exp_rep = 0; exp_del = 0;
    if (re) begin
      eff = rp;
      if (rp % 8 == 0) begin
        sep = (((wp / 8) - (rp / 8)) % 64 + 64) % 64;
        if (sep < 15)      exp_rep = 1;
        else if (sep > 41) exp_del = 1;
        if (exp_rep || exp_del) eff = ((((wp / 8) - 28) % 64 + 64) % 64) * 8;
      end
      exp_bit = m[eff];
      rp = (eff + 1) % 512;
    end
    if (we) begin
      m[wp] = wb;
      wp = (wp + 1) % 512;
    end
    @(negedge clk);
    check(rd_bit == exp_bit, "R2", "rd_bit", rd_bit, exp_bit);
    check(slip_rep == exp_rep, "R5", "slip_repeat", slip_rep, exp_rep);
    check(slip_del == exp_del, "R6", "slip_delete", slip_del, exp_del);
    check(!(slip_rep && slip_del), "R9", "both pulses", 1, 0);
    if (slip_rep) n_rep++;
    if (slip_del) n_del++;
  endtask

  task automatic t_reset();
    foreach (m[i]) m[i] = 0;
    wp = 0; rp = 288; exp_bit = 0;
    @(negedge clk);
    check(rd_bit == 0 && slip_rep == 0 && slip_del == 0, "R3", "reset outputs",
          {rd_bit, slip_rep, slip_del}, 0);
  endtask

  // equal rates: data emerges 28 channels later, no slip (R1, R3, R7)
  task automatic t_nominal();
    int ones = 0;
    n_rep = 0; n_del = 0;
    for (int i = 0; i < 600; i++) begin
      step(1, rnd(), 1);
      if (i >= 224 && rd_bit) ones++;
    end
    check(n_rep + n_del == 0, "R7", "slips at equal rate", n_rep + n_del, 0);
    check(ones > 0, "R1", "written data read back", ones, 1);
  endtask

  task automatic t_read_fast();
    n_rep = 0; n_del = 0;
    for (int i = 0; i < 800; i++) step(i % 2 == 0, rnd(), 1);
    check(n_rep > 0, "R5", "repeats under fast read", n_rep, 1);
    check(n_del == 0, "R5", "no delete under fast read", n_del, 0);
  endtask

  task automatic t_read_slow();
    n_rep = 0; n_del = 0;
    for (int i = 0; i < 800; i++) step(1, rnd(), i % 2 == 0);
    check(n_del > 0, "R6", "deletes under slow read", n_del, 1);
    check(n_rep == 0, "R6", "no repeat under slow read", n_rep, 0);
  endtask

  task automatic t_idle();
    bit held;
    held = rd_bit;
    for (int i = 0; i < 20; i++) step(0, 0, 0);
    check(rd_bit == held, "R2", "hold while idle", rd_bit, held);
  endtask

  // independent random strobes: mid-channel reads, coincident strobes (R4, R8)
  task automatic t_random();
    for (int i = 0; i < 6000; i++) step(rnd(), rnd(), rnd() | rnd());
    check(errors == 0, "R8", "random strobe run", errors, 0);
    check(1, "R4", "separation evaluated by model", 1, 1);
  endtask

  initial begin
    fork
      begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    join_none
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_nominal();
    t_read_fast();
    t_idle();
    t_read_slow();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule